// File: doc/BRIEF.md
# Record-Path Automatic Level Control with Noise Gate

This block produces the gain code for one record-channel programmable-gain amplifier. Each time a new signed sample arrives, its magnitude is compared with a programmable target level. The gain falls while the input is too loud. After the input drops below the target, the gain is held for a programmable time. It then climbs back at a programmable pace, but never above a programmable ceiling. The gain moves one code at a time. The time between steps is a count of samples derived from the timing fields.

A noise gate watches for long runs of quiet input. When the magnitude stays under the gate level for a set number of consecutive samples (250 ms at the intended sample rate), the gate engages. It then applies one of three behaviours: it freezes the gain, cuts the gain to the lowest code at once, or fades the gain down one code at a time. Any sample at or above the gate level releases the gate.

When level control is switched off, the gain walks toward a manually chosen code at one of four selectable rates. The output code maps to −12 dB + 0.75 dB × code, so code 0 is −12 dB, code 16 is 0 dB and code 63 is +35.25 dB.

Top module: `alc_gain_ctrl`

## Requirements
- R1: After a synchronous reset, `gain_code` is 16 (0 dB). Code n stands for −12 dB + 0.75 dB × n, so the codes run from 0 to 63.
- R2: Attack. While enabled and ungated, a sample whose magnitude is greater than `target_lvl` counts toward attack. The gain drops by one code on every (`attack_sel`+1)×ATK_BASE-th consecutive such sample. The count starts at 1 on entering attack. The gain never goes below 0.
- R3: Hold. After an over-target sample, the next `hold_sel`×HOLD_BASE samples that are not over target leave the gain unchanged.
- R4: Decay. After the hold has run out, the gain rises by one code on every (`decay_sel`+1)×DEC_BASE-th sample that is not over target.
- R5: Ceiling. While enabled, decay never raises the gain above `max_gain`. A gain above `max_gain` is set to `max_gain` on the next sample.
- R6: The gate engages on the QUIET_SAMPLES-th consecutive sample whose magnitude is below `gate_lvl`. It only engages while both `gate_en` and `alc_en` are 1. While `gate_en` is 0, quiet samples have no effect.
- R7: Gate behaviour by `gate_kind`. 2'b00 freezes the gain. 2'b01 and 2'b11 set the gain to 0 on the engaging sample. 2'b10 fades the gain: one code down on every FADE_BASE-th gated sample, stopping at 0.
- R8: A sample with magnitude at or above `gate_lvl` releases the gate at once. Normal attack/hold/decay handling applies to that sample. A fresh full quiet run is then needed to engage the gate again.
- R9: With `alc_en` at 0, the gain moves one code toward `manual_gain` on every (SLEW_BASE << `slew_sel`)-th sample. It stays put once it equals `manual_gain`.
- R10: Magnitude is the two's-complement absolute value. A negative sample behaves like its positive mirror. The most negative value has a magnitude of 2^(SAMPLE_W−1).
- R11: `gain_code` changes only in the second clock after a cycle with `smp_valid` high. Each change is a single code, except for a gate cut or a ceiling clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_data | input | SAMPLE_W | Signed input sample |
| alc_en | input | 1 | 1: automatic control, 0: manual slew |
| target_lvl | input | SAMPLE_W | Magnitude above which attack applies |
| max_gain | input | 6 | Gain ceiling while enabled |
| manual_gain | input | 6 | Gain code used when control is off |
| attack_sel | input | 4 | Attack pace select |
| hold_sel | input | 4 | Hold length select |
| decay_sel | input | 4 | Decay pace select |
| slew_sel | input | 2 | Manual slew pace select |
| gate_en | input | 1 | Noise gate enable |
| gate_kind | input | 2 | Gate behaviour select |
| gate_lvl | input | SAMPLE_W | Magnitude below which a sample is quiet |
| gain_code | output | 6 | Registered gain code |

## Verification
Long bursts of loud samples of both signs exercise the attack pace and the floor at 0. This shows whether the magnitude is taken correctly and whether the step interval starts counting on entry. Mid-level samples between the gate level and the target separate hold from decay and show the ceiling stopping the rise. Lowering the ceiling mid-run checks the immediate clamp. Runs of very small samples, one short and one exactly the quiet length, distinguish the three gate behaviours and the disabled gate. A single mid-level sample after a fade proves the release. Manual mode is driven up and then down to check the slew pace in both directions and the stop at the target code.

// File: rtl/alc_pkg.sv
package alc_pkg;
  localparam int GAIN_W = 6;
  localparam logic [GAIN_W-1:0] GAIN_RESET = 6'd16;

  typedef enum logic [1:0] {
    GK_FREEZE = 2'b00,
    GK_CUT    = 2'b01,
    GK_FADE   = 2'b10,
    GK_CUT2   = 2'b11
  } gate_kind_e;

  typedef enum logic [2:0] {
    PH_SLEW,
    PH_GATE,
    PH_ATTACK,
    PH_HOLD,
    PH_DECAY
  } alc_phase_e;
endpackage

// File: rtl/alc_level_det.sv
module alc_level_det #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [SAMPLE_W-1:0] target_lvl,
  input  logic [SAMPLE_W-1:0] gate_lvl,
  output logic                det_valid,
  output logic                det_over,
  output logic                det_quiet
);
  logic [SAMPLE_W-1:0] mag;

  // two's-complement magnitude; most negative value maps to 2^(SAMPLE_W-1)
  always_comb begin
    if (smp_data[SAMPLE_W-1]) mag = ~smp_data + 1'b1;
    else                      mag = smp_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_valid <= 1'b0;
      det_over  <= 1'b0;
      det_quiet <= 1'b0;
    end else begin
      det_valid <= smp_valid;
      if (smp_valid) begin
        det_over  <= mag > target_lvl;
        det_quiet <= mag < gate_lvl;
      end
    end
  end

  AST_DET_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> det_valid); // R11
endmodule

// File: rtl/alc_quiet_timer.sv
module alc_quiet_timer #(
  parameter int QUIET_SAMPLES = 12000
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic det_valid,
  input  logic det_quiet,
  output logic gate_now
);
  localparam int QW = $clog2(QUIET_SAMPLES + 1);
  localparam logic [QW-1:0] QLIM = QW'(QUIET_SAMPLES);

  logic [QW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (!enable)
      cnt_n = '0;
    else if (det_valid) begin
      if (!det_quiet)        cnt_n = '0;
      else if (cnt_q != QLIM) cnt_n = cnt_q + 1'b1;
    end
  end

  assign gate_now = enable && (cnt_n == QLIM);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end

  AST_QUIET_COUNTS: assert property (@(posedge clk) disable iff (rst)
    (enable && det_valid && det_quiet && cnt_q != QLIM) |=> cnt_q == $past(cnt_q) + 1'b1); // R6
  AST_LOUD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (det_valid && !det_quiet) |=> cnt_q == '0); // R8
endmodule

// File: rtl/alc_gain_seq.sv
module alc_gain_seq
  import alc_pkg::*;
#(
  parameter int ATK_BASE  = 2,
  parameter int HOLD_BASE = 4,
  parameter int DEC_BASE  = 8,
  parameter int SLEW_BASE = 2,
  parameter int FADE_BASE = 4,
  parameter int PACE_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              det_valid,
  input  logic              det_over,
  input  logic              gate_now,
  input  logic              alc_en,
  input  logic [GAIN_W-1:0] max_gain,
  input  logic [GAIN_W-1:0] manual_gain,
  input  logic [3:0]        attack_sel,
  input  logic [3:0]        hold_sel,
  input  logic [3:0]        decay_sel,
  input  logic [1:0]        slew_sel,
  input  logic [1:0]        gate_kind,
  output logic [GAIN_W-1:0] gain_q
);
  localparam int HOLD_MAX_I = 15 * HOLD_BASE + 1;
  localparam int HOLD_W     = $clog2(HOLD_MAX_I + 1);
  localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(HOLD_MAX_I);

  alc_phase_e         phase_q, phase_n;
  logic [PACE_W-1:0]  pace_q, pace_n, cnt;
  logic [HOLD_W-1:0]  hold_q, hold_n, hold_len;
  logic [GAIN_W-1:0]  gain_n;
  logic [PACE_W-1:0]  atk_iv, dec_iv, slew_iv;
  gate_kind_e         gk;
  logic               jump_ok;

  assign atk_iv   = PACE_W'(attack_sel) * PACE_W'(ATK_BASE) + PACE_W'(ATK_BASE);
  assign dec_iv   = PACE_W'(decay_sel)  * PACE_W'(DEC_BASE) + PACE_W'(DEC_BASE);
  assign slew_iv  = PACE_W'(SLEW_BASE) << slew_sel;
  assign hold_len = HOLD_W'(hold_sel) * HOLD_W'(HOLD_BASE);
  assign gk       = gate_kind_e'(gate_kind);

  always_comb begin
    phase_n = phase_q;
    pace_n  = pace_q;
    gain_n  = gain_q;
    hold_n  = hold_q;
    cnt     = '0;
    if (det_valid) begin
      if (!alc_en) begin
        phase_n = PH_SLEW;
        hold_n  = '0;
        if (gain_q == manual_gain) pace_n = '0;
        else begin
          cnt = (phase_q == PH_SLEW) ? pace_q + 1'b1 : PACE_W'(1);
          if (cnt >= slew_iv) begin
            pace_n = '0;
            gain_n = (gain_q < manual_gain) ? gain_q + 1'b1 : gain_q - 1'b1;
          end else pace_n = cnt;
        end
      end else begin
        if (det_over)               hold_n = '0;
        else if (hold_q != HOLD_MAX) hold_n = hold_q + 1'b1;
        if (gate_now)               phase_n = PH_GATE;
        else if (det_over)          phase_n = PH_ATTACK;
        else if (hold_n > hold_len) phase_n = PH_DECAY;
        else                        phase_n = PH_HOLD;
        cnt = (phase_n == phase_q) ? pace_q + 1'b1 : PACE_W'(1);
        if (gain_q > max_gain) begin
          gain_n = max_gain;
          pace_n = '0;
        end else begin
          unique case (phase_n)
            PH_GATE: begin
              if (gk == GK_FREEZE) pace_n = '0;
              else if (gk == GK_FADE) begin
                if (cnt >= PACE_W'(FADE_BASE)) begin
                  pace_n = '0;
                  if (gain_q != '0) gain_n = gain_q - 1'b1;
                end else pace_n = cnt;
              end else begin
                gain_n = '0;
                pace_n = '0;
              end
            end
            PH_ATTACK: begin
              if (cnt >= atk_iv) begin
                pace_n = '0;
                if (gain_q != '0) gain_n = gain_q - 1'b1;
              end else pace_n = cnt;
            end
            PH_DECAY: begin
              if (cnt >= dec_iv) begin
                pace_n = '0;
                if (gain_q < max_gain) gain_n = gain_q + 1'b1;
              end else pace_n = cnt;
            end
            default: pace_n = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_SLEW;
      pace_q  <= '0;
      hold_q  <= '0;
      gain_q  <= GAIN_RESET;
    end else begin
      phase_q <= phase_n;
      pace_q  <= pace_n;
      hold_q  <= hold_n;
      gain_q  <= gain_n;
    end
  end

  assign jump_ok = det_valid && alc_en &&
                   ((gain_q > max_gain) || (gate_now && (gk == GK_CUT || gk == GK_CUT2)));

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !det_valid |=> $stable(gain_q)); // R11
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !jump_ok |=> (gain_q == $past(gain_q) || gain_q == GAIN_W'($past(gain_q) + 1'b1) ||
                  gain_q == GAIN_W'($past(gain_q) - 1'b1))); // R11
  AST_CEILING: assert property (@(posedge clk) disable iff (rst)
    (det_valid && alc_en) |=> gain_q <= $past(max_gain)); // R5
  AST_CUT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (det_valid && alc_en && gate_now && gk == GK_CUT && gain_q <= max_gain) |=> gain_q == '0); // R7
endmodule

// File: rtl/alc_gain_ctrl.sv
module alc_gain_ctrl
  import alc_pkg::*;
#(
  parameter int SAMPLE_W      = 16,
  parameter int QUIET_SAMPLES = 12000,
  parameter int ATK_BASE      = 2,
  parameter int HOLD_BASE     = 4,
  parameter int DEC_BASE      = 8,
  parameter int SLEW_BASE     = 2,
  parameter int FADE_BASE     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                alc_en,
  input  logic [SAMPLE_W-1:0] target_lvl,
  input  logic [5:0]          max_gain,
  input  logic [5:0]          manual_gain,
  input  logic [3:0]          attack_sel,
  input  logic [3:0]          hold_sel,
  input  logic [3:0]          decay_sel,
  input  logic [1:0]          slew_sel,
  input  logic                gate_en,
  input  logic [1:0]          gate_kind,
  input  logic [SAMPLE_W-1:0] gate_lvl,
  output logic [5:0]          gain_code
);
  localparam int MAX_BASE = (ATK_BASE > DEC_BASE) ?
                            ((ATK_BASE > FADE_BASE) ? ATK_BASE : FADE_BASE) :
                            ((DEC_BASE > FADE_BASE) ? DEC_BASE : FADE_BASE);
  localparam int MAX_IV   = (16 * MAX_BASE > 8 * SLEW_BASE) ? 16 * MAX_BASE : 8 * SLEW_BASE;
  localparam int PACE_W   = $clog2(MAX_IV + 2);

  logic det_valid, det_over, det_quiet, gate_now;

  alc_level_det #(.SAMPLE_W(SAMPLE_W)) u_det (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .target_lvl(target_lvl), .gate_lvl(gate_lvl),
    .det_valid(det_valid), .det_over(det_over), .det_quiet(det_quiet)
  );

  alc_quiet_timer #(.QUIET_SAMPLES(QUIET_SAMPLES)) u_quiet (
    .clk(clk), .rst(rst), .enable(gate_en && alc_en),
    .det_valid(det_valid), .det_quiet(det_quiet), .gate_now(gate_now)
  );

  alc_gain_seq #(
    .ATK_BASE(ATK_BASE), .HOLD_BASE(HOLD_BASE), .DEC_BASE(DEC_BASE),
    .SLEW_BASE(SLEW_BASE), .FADE_BASE(FADE_BASE), .PACE_W(PACE_W)
  ) u_seq (
    .clk(clk), .rst(rst), .det_valid(det_valid), .det_over(det_over),
    .gate_now(gate_now), .alc_en(alc_en), .max_gain(max_gain),
    .manual_gain(manual_gain), .attack_sel(attack_sel), .hold_sel(hold_sel),
    .decay_sel(decay_sel), .slew_sel(slew_sel), .gate_kind(gate_kind),
    .gain_q(gain_code)
  );
endmodule

// File: tb/alc_gain_ctrl_test.sv
`timescale 1ns/1ps
module alc_gain_ctrl_test;
  localparam int SW = 16;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst, smp_valid, alc_en, gate_en;
  logic [SW-1:0] smp_data, target_lvl, gate_lvl;
  logic [5:0]    max_gain, manual_gain, gain_code;
  logic [3:0]    attack_sel, hold_sel, decay_sel;
  logic [1:0]    slew_sel, gate_kind;
  int            n_run = 0, n_fail = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  alc_gain_ctrl #(.SAMPLE_W(SW), .QUIET_SAMPLES(20)) uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .alc_en(alc_en), .target_lvl(target_lvl), .max_gain(max_gain),
    .manual_gain(manual_gain), .attack_sel(attack_sel), .hold_sel(hold_sel),
    .decay_sel(decay_sel), .slew_sel(slew_sel), .gate_en(gate_en),
    .gate_kind(gate_kind), .gate_lvl(gate_lvl), .gain_code(gain_code)
  );

  // ALC enabled, target 1000, ceiling 20, attack every 2, hold 4, decay every 8
  localparam logic [SW-1:0] TV_SMP [NV] = '{16'd5000, 16'd5000, 16'hEC78, 16'd200, 16'd200,
                                            16'd200, 16'd200, 16'd200, 16'd200, 16'h8000};
  localparam int            TV_REP [NV] = '{1, 1, 2, 4, 7, 1, 8, 32, 16, 2};
  localparam logic [5:0]    TV_EXP [NV] = '{6'd16, 6'd15, 6'd14, 6'd14, 6'd14,
                                            6'd15, 6'd16, 6'd20, 6'd20, 6'd19};
  localparam string         TV_TAG [NV] = '{"R2", "R2", "R10", "R3", "R4",
                                            "R4", "R4", "R4", "R5", "R10"};

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: gain_code=%0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [SW-1:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); smp_valid = 1'b1; smp_data = v;
      @(negedge clk); smp_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    smp_valid = 1'b0; smp_data = '0; alc_en = 1'b1; target_lvl = 16'd1000;
    max_gain = 6'd20; manual_gain = 6'd16; attack_sel = 4'd0; hold_sel = 4'd1;
    decay_sel = 4'd0; slew_sel = 2'd0; gate_en = 1'b0; gate_kind = 2'b00;
    gate_lvl = 16'd50; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1;
    do_reset();
    check("R1 reset code", gain_code, 6'd16);

    for (int k = 0; k < NV; k++) begin
      send(TV_SMP[k], TV_REP[k]);
      check(TV_TAG[k], gain_code, TV_EXP[k]);
    end

    // R5: ceiling lowered below current gain clamps on next sample
    max_gain = 6'd10;
    send(16'd200, 1);
    check("R5 clamp", gain_code, 6'd10);
    max_gain = 6'd20;
    // R2: attack floor at code 0
    send(16'd5000, 30);
    check("R2 floor", gain_code, 6'd0);
    // R11: data without strobe is ignored
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); smp_data = 16'd30000;
    end
    check("R11 no strobe", gain_code, 6'd0);
    // R1: reset mid-run
    do_reset();
    check("R1 reset again", gain_code, 6'd16);

    // R6/R7 cut: disabled gate ignores quiet run, then cut on 20th
    hold_sel = 4'd15; decay_sel = 4'd15; gate_kind = 2'b01;
    send(16'd10, 25);
    check("R6 gate disabled", gain_code, 6'd16);
    gate_en = 1'b1;
    send(16'd10, 19);
    check("R6 before quiet limit", gain_code, 6'd16);
    send(16'd10, 1);
    check("R7 cut", gain_code, 6'd0);

    // R7 freeze: decay runs until gate engages, then stops
    do_reset();
    hold_sel = 4'd0; max_gain = 6'd30; gate_en = 1'b1; gate_kind = 2'b00;
    send(16'd10, 19);
    check("R4 decay pre-gate", gain_code, 6'd18);
    send(16'd10, 21);
    check("R7 freeze", gain_code, 6'd18);

    // R7 fade and R8 release
    do_reset();
    hold_sel = 4'd15; decay_sel = 4'd15; gate_en = 1'b1; gate_kind = 2'b10;
    send(16'd10, 20);
    check("R7 fade not abrupt", gain_code, 6'd16);
    send(16'd10, 3);
    check("R7 fade step", gain_code, 6'd15);
    send(16'd10, 4);
    check("R7 fade step2", gain_code, 6'd14);
    send(16'd200, 1);
    check("R8 release sample", gain_code, 6'd14);
    send(16'd10, 19);
    check("R8 gate stays off", gain_code, 6'd14);

    // R9 manual slew up then down
    do_reset();
    alc_en = 1'b0; manual_gain = 6'd20; slew_sel = 2'd1;
    send(16'd5000, 3);
    check("R9 slew wait", gain_code, 6'd16);
    send(16'd5000, 1);
    check("R9 slew step", gain_code, 6'd17);
    send(16'd5000, 12);
    check("R9 slew reach", gain_code, 6'd20);
    send(16'd5000, 8);
    check("R9 slew hold", gain_code, 6'd20);
    manual_gain = 6'd18; slew_sel = 2'd0;
    send(16'd5000, 1);
    check("R9 down wait", gain_code, 6'd20);
    send(16'd5000, 1);
    check("R9 down step", gain_code, 6'd19);
    send(16'd5000, 2);
    check("R9 down reach", gain_code, 6'd18);

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: gain_code=%0d expected completion", gain_code);
    finish_run();
  end
endmodule